// File: doc/BRIEF.md
# Receive Packet Length and Address Filter

This block sits on the receive side of a packet radio, directly behind sync-word detection. It takes the byte stream that follows each sync word and decides where the packet ends. The end comes from one of three sources: a configured byte count, a length byte carried in the packet, or no count at all. The block compares the packet's destination address byte against a device address and optional broadcast values. It checks a trailing CRC-16 when that check is enabled. Bytes of kept packets leave the block with start and end flags. At the end of each packet the block reports whether the packet was accepted or dropped, and whether its CRC was good.

The configuration inputs are sampled on the first byte of every packet. This lets software retune the filter while a packet is in flight without corrupting that packet. An unbounded packet is closed by moving the length mode away from unbounded. The block holds off input for the single cycle in which it closes that packet.

Top module: `rx_frm_filter`

## Requirements
- R1: Length mode 00 (and the reserved 11, handled identically) is fixed length: each packet carries exactly `cfg_fixed_len` counted bytes, and the last of them is flagged with `out_eop`.
- R2: Length mode 01 is variable length: the first byte after sync holds the count of address and payload bytes (CRC bytes excluded), and that length byte is never output.
- R3: A variable-length byte of zero ends the packet at once: no byte is output, no CRC bytes are expected, and `pkt_accept` with `crc_ok` pulses in the cycle after the length byte.
- R4: Length mode 10 is unbounded: no byte count ends the packet and `out_eop` never rises. While such a packet is open, a length mode other than 10 closes it. In that cycle `in_ready` is low, and the status pulses one cycle later.
- R5: The first counted byte is the address byte. Address mode 00 keeps every packet, 01 keeps only the device address, 10 also keeps 0x00, and 11 also keeps 0x00 and 0xFF.
- R6: A packet that fails the address check produces no output byte. Its remaining bytes are still consumed, and `pkt_drop` pulses for one cycle after the packet's last byte.
- R7: With CRC enabled, two CRC bytes follow the counted bytes, high byte first. The CRC is CRC-16 with polynomial 0x8005 and initial value 0xFFFF, shifted MSB first. It covers the length byte (variable mode) or the first byte (fixed mode) through the last counted byte. `crc_ok` pulses with `pkt_accept` only when the received value matches.
- R8: With CRC disabled, no CRC bytes are expected, and `crc_ok` pulses with every `pkt_accept`.
- R9: A change to any configuration input after a packet's first byte leaves that packet's length, address check and CRC handling unchanged.
- R10: Status pulses last one cycle and come in the cycle after the packet's final byte. `pkt_accept` and `pkt_drop` never rise together, and `crc_ok` is high only together with `pkt_accept`.
- R11: After reset, all outputs are low except `in_ready`, which is high.
- R12: A fixed length of zero is handled as a one-byte packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_mode | input | 2 | 00 fixed, 01 variable, 10 unbounded, 11 fixed |
| cfg_fixed_len | input | 8 | Counted bytes per packet in fixed mode |
| cfg_dev_addr | input | 8 | Device address |
| cfg_addr_mode | input | 2 | Address check mode (see R5) |
| cfg_crc_en | input | 1 | CRC check enable |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (address and payload) |
| out_sop | output | 1 | First output byte of a packet |
| out_eop | output | 1 | Last output byte of a packet |
| pkt_accept | output | 1 | Packet kept, one-cycle pulse |
| pkt_drop | output | 1 | Packet dropped by address, one-cycle pulse |
| crc_ok | output | 1 | CRC good or not checked, with `pkt_accept` |

## Verification
The in-line assertions check, on every cycle, the invariants of the status outputs. They also check that a counted body never runs with a zero remaining count, that a zero length byte and a final CRC byte always yield a status pulse, and that closing an unbounded packet always yields one. Whether each address mode keeps the right packets, whether the byte count and CRC coverage are right, and whether mid-packet configuration changes are ignored can only be seen in the bench's sweeps. Those sweeps compute each expected stream and each expected status arithmetically.

// File: rtl/rx_frm_pkg.sv
package rx_frm_pkg;
   localparam int BYTE_W = 8;

   localparam logic [1:0] LM_FIXED = 2'b00;
   localparam logic [1:0] LM_VAR   = 2'b01;
   localparam logic [1:0] LM_INF   = 2'b10;

   localparam logic [1:0] AM_NONE  = 2'b00;
   localparam logic [1:0] AM_DEV   = 2'b01;
   localparam logic [1:0] AM_LO    = 2'b10;
   localparam logic [1:0] AM_BOTH  = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BODY,
      ST_INF,
      ST_CRC_HI,
      ST_CRC_LO
   } rx_state_e;
endpackage

// File: rtl/rx_frm_addr_match.sv
module rx_frm_addr_match
   import rx_frm_pkg::*;
#(
   parameter int         W     = 8,
   parameter logic [W-1:0] BC_LO = '0,
   parameter logic [W-1:0] BC_HI = '1
) (
   input  logic [1:0]   mode,
   input  logic [W-1:0] dev_addr,
   input  logic [W-1:0] addr,
   output logic         hit
);
   if (W < 1) begin : g_bad_w
      $error("rx_frm_addr_match: W must be positive");
   end
   if (BC_LO == BC_HI) begin : g_bad_bc
      $error("rx_frm_addr_match: broadcast values must differ");
   end

   logic is_dev, is_lo, is_hi;

   always_comb begin
      is_dev = (addr == dev_addr);
      is_lo  = (addr == BC_LO);
      is_hi  = (addr == BC_HI);
      unique case (mode)
         AM_NONE: hit = 1'b1;
         AM_DEV:  hit = is_dev;
         AM_LO:   hit = is_dev | is_lo;
         default: hit = is_dev | is_lo | is_hi;
      endcase
   end
endmodule

// File: rtl/rx_frm_len_sel.sv
module rx_frm_len_sel
   import rx_frm_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic [1:0]       mode,
   input  logic [LEN_W-1:0] fixed_len,
   output logic [LEN_W-1:0] start_len,
   output logic             is_var,
   output logic             is_inf
);
   if (LEN_W < 1 || LEN_W > BYTE_W) begin : g_bad_len
      $error("rx_frm_len_sel: LEN_W must be 1..8");
   end

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   always_comb begin
      is_var    = (mode == LM_VAR);
      is_inf    = (mode == LM_INF);
      start_len = (fixed_len == '0) ? ONE : fixed_len;
   end
endmodule

// File: rtl/rx_frm_crc.sv
module rx_frm_crc #(
   parameter int             CRC_W = 16,
   parameter int             DW    = 8,
   parameter logic [CRC_W-1:0] POLY  = 16'h8005,
   parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             update,
   input  logic [DW-1:0]    data,
   output logic [CRC_W-1:0] crc
);
   if (CRC_W < DW) begin : g_bad_crc
      $error("rx_frm_crc: CRC_W must be at least DW");
   end

   function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c_in,
                                             input logic [DW-1:0] d);
      logic [CRC_W-1:0] c;
      logic fb;
      c = c_in;
      for (int i = DW - 1; i >= 0; i--) begin
         fb = c[CRC_W-1] ^ d[i];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] base;

   always_comb base = restart ? INIT : crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= INIT;
      else if (update) crc_q <= step(base, data);
   end

   assign crc = crc_q;
endmodule

// File: rtl/rx_frm_filter.sv
module rx_frm_filter
   import rx_frm_pkg::*;
#(
   parameter logic [7:0]  BCAST_LO    = 8'h00,
   parameter logic [7:0]  BCAST_HI    = 8'hFF,
   parameter int          CRC_SUPPORT = 1,
   parameter logic [15:0] CRC_POLY    = 16'h8005,
   parameter logic [15:0] CRC_INIT    = 16'hFFFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_len_mode,
   input  logic [7:0] cfg_fixed_len,
   input  logic [7:0] cfg_dev_addr,
   input  logic [1:0] cfg_addr_mode,
   input  logic       cfg_crc_en,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_sop,
   output logic       out_eop,
   output logic       pkt_accept,
   output logic       pkt_drop,
   output logic       crc_ok
);
   localparam int CRC_W = 16;
   localparam int LEN_W = BYTE_W;
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   if (CRC_SUPPORT != 0 && CRC_SUPPORT != 1) begin : g_bad_opt
      $error("rx_frm_filter: CRC_SUPPORT must be 0 or 1");
   end

   rx_state_e         state_q;
   logic [1:0]        amode_q;
   logic [7:0]        dev_q;
   logic              crc_en_q;
   logic [LEN_W-1:0]  remain_q;
   logic              first_q;
   logic              keep_q;
   logic [7:0]        crc_hi_q;

   logic              idle, inf_close, fire, body_fire, last_body, zero_len, crc_fin;
   logic [1:0]        amode_c;
   logic [7:0]        dev_c;
   logic              crc_en_c, first_c, keep_c, inf_c, hit, crc_match;
   logic              finish, fin_keep, fin_crc;
   logic [LEN_W-1:0]  remain_c, start_len;
   logic              lc_var, lc_inf;
   logic [CRC_W-1:0]  crc_val;

   rx_frm_len_sel #(.LEN_W(LEN_W)) u_len (
      .mode      (cfg_len_mode),
      .fixed_len (cfg_fixed_len),
      .start_len (start_len),
      .is_var    (lc_var),
      .is_inf    (lc_inf)
   );

   always_comb begin
      idle      = (state_q == ST_IDLE);
      inf_close = (state_q == ST_INF) && (cfg_len_mode != LM_INF);
      in_ready  = rst_n && !inf_close;
      fire      = in_valid && in_ready;
      amode_c   = idle ? cfg_addr_mode : amode_q;
      dev_c     = idle ? cfg_dev_addr : dev_q;
      crc_en_c  = idle ? (cfg_crc_en && (CRC_SUPPORT == 1)) : crc_en_q;
      inf_c     = idle ? lc_inf : (state_q == ST_INF);
      remain_c  = idle ? start_len : remain_q;
      first_c   = idle || first_q;
   end

   rx_frm_addr_match #(.W(8), .BC_LO(BCAST_LO), .BC_HI(BCAST_HI)) u_addr (
      .mode     (amode_c),
      .dev_addr (dev_c),
      .addr     (in_data),
      .hit      (hit)
   );

   if (CRC_SUPPORT == 1) begin : g_crc
      rx_frm_crc #(.CRC_W(CRC_W), .DW(8), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (fire && idle),
         .update  (fire && (idle || state_q == ST_BODY)),
         .data    (in_data),
         .crc     (crc_val)
      );
   end else begin : g_no_crc
      assign crc_val = '0;
   end

   always_comb begin
      body_fire = fire && ((idle && !lc_var) || state_q == ST_BODY || state_q == ST_INF);
      keep_c    = first_c ? hit : keep_q;
      last_body = body_fire && !inf_c && (remain_c == ONE);
      zero_len  = fire && idle && lc_var && (in_data == 8'h00);
      crc_fin   = fire && (state_q == ST_CRC_LO);
      crc_match = ({crc_hi_q, in_data} == crc_val);
      finish    = inf_close || zero_len || (last_body && !crc_en_c) || crc_fin;
      if (zero_len)       fin_keep = 1'b1;
      else if (last_body) fin_keep = keep_c;
      else                fin_keep = keep_q;
      fin_crc   = crc_fin ? crc_match : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         amode_q  <= AM_NONE;
         dev_q    <= '0;
         crc_en_q <= 1'b0;
         remain_q <= '0;
         first_q  <= 1'b0;
         keep_q   <= 1'b0;
         crc_hi_q <= '0;
      end else if (inf_close) begin
         state_q <= ST_IDLE;
         first_q <= 1'b0;
      end else if (fire) begin
         if (idle) begin
            amode_q  <= cfg_addr_mode;
            dev_q    <= cfg_dev_addr;
            crc_en_q <= cfg_crc_en && (CRC_SUPPORT == 1);
         end
         if (body_fire) begin
            keep_q   <= keep_c;
            first_q  <= 1'b0;
            remain_q <= remain_c - ONE;
            if (inf_c)                 state_q <= ST_INF;
            else if (remain_c != ONE)  state_q <= ST_BODY;
            else if (crc_en_c)         state_q <= ST_CRC_HI;
            else                       state_q <= ST_IDLE;
         end else if (idle) begin
            remain_q <= in_data;
            first_q  <= (in_data != 8'h00);
            keep_q   <= 1'b1;
            state_q  <= (in_data == 8'h00) ? ST_IDLE : ST_BODY;
         end else if (state_q == ST_CRC_HI) begin
            crc_hi_q <= in_data;
            state_q  <= ST_CRC_LO;
         end else begin
            state_q  <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_sop    <= 1'b0;
         out_eop    <= 1'b0;
         pkt_accept <= 1'b0;
         pkt_drop   <= 1'b0;
         crc_ok     <= 1'b0;
      end else begin
         out_valid  <= body_fire && keep_c;
         out_data   <= in_data;
         out_sop    <= body_fire && keep_c && first_c;
         out_eop    <= last_body && keep_c;
         pkt_accept <= finish && fin_keep;
         pkt_drop   <= finish && !fin_keep;
         crc_ok     <= finish && fin_keep && fin_crc;
      end
   end

   // R10: status pulses are exclusive and crc_ok rides only on accept
   p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_accept && pkt_drop));
   p_crcok_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      crc_ok |-> pkt_accept);
   // R6: the closing cycle of a dropped packet carries no output byte
   p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_drop |-> !out_valid);
   // R1: a counted body never runs with nothing left to count
   p_remain_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BODY) |-> (remain_q != '0));
   // R3: a zero length byte closes the packet at once
   p_zero_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && state_q == ST_IDLE && cfg_len_mode == LM_VAR && in_data == 8'h00)
      |=> (pkt_accept && crc_ok && !out_valid));
   // R4: leaving unbounded mode closes the open packet with a status
   p_inf_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INF && cfg_len_mode != LM_INF) |=> (pkt_accept || pkt_drop));
   // R4: unbounded packets never flag an end byte
   p_inf_no_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INF) |=> !out_eop);
   // R7: the second CRC byte always finishes the packet
   p_crc_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && state_q == ST_CRC_LO) |=> (pkt_accept || pkt_drop));
endmodule

// File: tb/rx_frm_filter_bench.sv
module rx_frm_filter_bench;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_len_mode = 2'b00;
   logic [7:0] cfg_fixed_len = 8'd1;
   logic [7:0] cfg_dev_addr = 8'h5A;
   logic [1:0] cfg_addr_mode = 2'b00;
   logic       cfg_crc_en = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       out_valid, out_sop, out_eop, pkt_accept, pkt_drop, crc_ok;
   logic [7:0] out_data;

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   logic [7:0] pkt [0:599];
   logic [7:0] cap [0:599];
   bit         cap_sop [0:599];
   bit         cap_eop [0:599];
   int cap_n, acc_n, drop_n, ok_n;

   rx_frm_filter u_rx_frm_filter (
      .clk(clk), .rst_n(rst_n),
      .cfg_len_mode(cfg_len_mode), .cfg_fixed_len(cfg_fixed_len),
      .cfg_dev_addr(cfg_dev_addr), .cfg_addr_mode(cfg_addr_mode),
      .cfg_crc_en(cfg_crc_en),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .pkt_accept(pkt_accept), .pkt_drop(pkt_drop),
      .crc_ok(crc_ok)
   );

   always #(CLK_PER / 2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++) begin
         for (int b = 7; b >= 0; b--) begin
            if (c[15] ^ pkt[k][b]) c = {c[14:0], 1'b0} ^ 16'h8005;
            else                   c = {c[14:0], 1'b0};
         end
      end
      return c;
   endfunction

   function automatic bit ref_hit(input logic [1:0] am, input logic [7:0] dev, input logic [7:0] a);
      case (am)
         2'b00:   return 1'b1;
         2'b01:   return a == dev;
         2'b10:   return (a == dev) || (a == 8'h00);
         default: return (a == dev) || (a == 8'h00) || (a == 8'hFF);
      endcase
   endfunction

   task automatic sample();
      if (out_valid) begin
         cap[cap_n]     = out_data;
         cap_sop[cap_n] = out_sop;
         cap_eop[cap_n] = out_eop;
         cap_n++;
      end
      if (pkt_accept) acc_n++;
      if (pkt_drop)   drop_n++;
      if (crc_ok)     ok_n++;
   endtask

   task automatic cycle(input logic v, input logic [7:0] d);
      @(negedge clk);
      sample();
      in_valid = v;
      in_data  = d;
   endtask

   task automatic clear_cap();
      cap_n = 0; acc_n = 0; drop_n = 0; ok_n = 0;
   endtask

   // Sends one counted packet and checks its output stream and status.
   task automatic run_pkt(input logic [1:0] lm, input logic [7:0] flen, input logic [1:0] am,
                          input bit ce, input logic [7:0] adr, input bit corrupt,
                          input bit chg, input string tag);
      int L, n, off;
      logic [15:0] c;
      bit hit, flags_ok, data_ok;
      L   = (lm == 2'b01) ? int'(flen) : ((flen == 8'd0) ? 1 : int'(flen));
      off = (lm == 2'b01) ? 1 : 0;
      n = 0;
      if (lm == 2'b01) begin pkt[n] = flen; n++; end
      for (int i = 0; i < L; i++) begin
         pkt[n] = (i == 0) ? adr : 8'((i * 37) + (int'(lm) * 5) + 3);
         n++;
      end
      if (ce && L > 0) begin
         c = ref_crc(n);
         pkt[n] = c[15:8]; n++;
         pkt[n] = c[7:0] ^ {7'd0, corrupt}; n++;
      end
      cfg_len_mode = lm; cfg_fixed_len = flen; cfg_addr_mode = am; cfg_crc_en = ce;
      clear_cap();
      for (int i = 0; i < n; i++) begin
         cycle(1'b1, pkt[i]);
         if (chg && i == 1) begin
            cfg_fixed_len = flen + 8'd4;
            cfg_dev_addr  = cfg_dev_addr ^ 8'h01;
            cfg_crc_en    = !ce;
            cfg_addr_mode = 2'b01;
            cfg_len_mode  = (lm == 2'b01) ? 2'b00 : 2'b01;
         end
      end
      for (int i = 0; i < 3; i++) cycle(1'b0, 8'h00);
      if (chg) cfg_dev_addr = 8'h5A;
      hit = (L == 0) ? 1'b1 : ref_hit(am, 8'h5A, adr);
      if (hit) begin
         chk(cap_n == L, {tag, " count"}, cap_n, L);
         data_ok = 1; flags_ok = 1;
         for (int i = 0; i < L && i < cap_n; i++) begin
            if (cap[i] != pkt[i + off]) data_ok = 0;
            if (cap_sop[i] != (i == 0) || cap_eop[i] != (i == L - 1)) flags_ok = 0;
         end
         chk(data_ok, {tag, " data"}, data_ok, 1);
         chk(flags_ok, {tag, " sop/eop"}, flags_ok, 1);
         chk(acc_n == 1 && drop_n == 0, {tag, " accept"}, acc_n, 1);
         chk(ok_n == ((ce && corrupt) ? 0 : 1), {tag, " crc_ok"}, ok_n, (ce && corrupt) ? 0 : 1);
      end else begin
         chk(cap_n == 0, {tag, " drop silent"}, cap_n, 0);
         chk(drop_n == 1 && acc_n == 0 && ok_n == 0, {tag, " drop pulse"}, drop_n, 1);
      end
   endtask

   // Sends an unbounded packet, then closes it by switching the length mode.
   task automatic run_inf(input logic [1:0] am, input logic [7:0] adr, input int nb, input string tag);
      bit hit, data_ok;
      int eops, sops;
      cfg_len_mode = 2'b10; cfg_addr_mode = am; cfg_crc_en = 1'b1;
      clear_cap();
      for (int i = 0; i < nb; i++) begin
         pkt[i] = (i == 0) ? adr : 8'(i * 11 + 1);
         cycle(1'b1, pkt[i]);
      end
      cycle(1'b0, 8'h00);
      cycle(1'b0, 8'h00);
      chk(acc_n == 0 && drop_n == 0, {tag, " R4 open"}, acc_n + drop_n, 0);
      @(negedge clk);
      sample();
      cfg_len_mode = 2'b00;
      in_valid = 1'b1; in_data = 8'h77;
      #1;
      chk(in_ready == 1'b0, {tag, " R4 ready low on close"}, in_ready, 0);
      @(negedge clk);
      sample();
      in_valid = 1'b0;
      for (int i = 0; i < 2; i++) cycle(1'b0, 8'h00);
      hit = ref_hit(am, 8'h5A, adr);
      eops = 0; sops = 0; data_ok = 1;
      for (int i = 0; i < cap_n; i++) begin
         if (cap_eop[i]) eops++;
         if (cap_sop[i]) sops++;
         if (cap[i] != pkt[i]) data_ok = 0;
      end
      chk(cap_n == (hit ? nb : 0), {tag, " R4 count"}, cap_n, hit ? nb : 0);
      chk(eops == 0 && data_ok, {tag, " R4 no eop"}, eops, 0);
      chk(acc_n == int'(hit) && drop_n == int'(!hit) && ok_n == int'(hit),
          {tag, " R4 close status"}, acc_n, int'(hit));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [7:0] adrs [0:3];
      logic [7:0] lens [0:2];
      logic [1:0] lms [0:2];
      adrs[0] = 8'h5A; adrs[1] = 8'h00; adrs[2] = 8'hFF; adrs[3] = 8'h33;
      lens[0] = 8'd1;  lens[1] = 8'd2;  lens[2] = 8'd5;
      lms[0]  = 2'b00; lms[1]  = 2'b01; lms[2]  = 2'b11;
      clear_cap();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: quiet outputs and ready input after reset
      chk(!out_valid && !out_sop && !out_eop && !pkt_accept && !pkt_drop && !crc_ok,
          "R11 outputs low", out_valid, 0);
      chk(in_ready == 1'b1, "R11 ready high", in_ready, 1);

      // R1 R2 R5 R6 R7 R8: sweep length modes, address modes, CRC and addresses
      for (int m = 0; m < 3; m++)
         for (int am = 0; am < 4; am++)
            for (int ce = 0; ce < 2; ce++)
               for (int a = 0; a < 4; a++)
                  for (int l = 0; l < 3; l++)
                     run_pkt(lms[m], lens[l], 2'(am), ce[0], adrs[a], 1'b0, 1'b0,
                             $sformatf("R1/R2/R5/R6/R8 lm=%0d am=%0d ce=%0d a=%0h l=%0d",
                                       lms[m], am, ce, adrs[a], lens[l]));

      // R7: corrupted CRC is flagged, in both counted modes
      run_pkt(2'b00, 8'd4, 2'b01, 1'b1, 8'h5A, 1'b1, 1'b0, "R7 fixed bad crc");
      run_pkt(2'b01, 8'd6, 2'b11, 1'b1, 8'hFF, 1'b1, 1'b0, "R7 var bad crc");
      run_pkt(2'b01, 8'd9, 2'b01, 1'b1, 8'h5A, 1'b0, 1'b0, "R7 var good crc");
      run_pkt(2'b01, 8'd7, 2'b01, 1'b1, 8'h34, 1'b1, 1'b0, "R6 dropped bad crc");

      // R3: zero variable length, with and without CRC
      run_pkt(2'b01, 8'd0, 2'b01, 1'b1, 8'h00, 1'b0, 1'b0, "R3 zero len crc on");
      run_pkt(2'b01, 8'd0, 2'b01, 1'b0, 8'h00, 1'b0, 1'b0, "R3 zero len crc off");

      // R12: fixed length zero acts as one byte
      run_pkt(2'b00, 8'd0, 2'b00, 1'b1, 8'h21, 1'b0, 1'b0, "R12 fixed zero");

      // R9: configuration changes mid packet do not disturb it
      run_pkt(2'b00, 8'd5, 2'b01, 1'b1, 8'h5A, 1'b0, 1'b1, "R9 fixed change");
      run_pkt(2'b01, 8'd6, 2'b00, 1'b0, 8'h44, 1'b0, 1'b1, "R9 var change");

      // R4: unbounded packets past the largest count, kept and dropped
      run_inf(2'b01, 8'h5A, 300, "inf keep");
      run_inf(2'b01, 8'h12, 20, "inf drop");

      // R10: packet after unbounded runs normally
      run_pkt(2'b00, 8'd3, 2'b10, 1'b1, 8'h00, 1'b0, 1'b0, "R10 after inf");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule